// File: doc/BRIEF.md
# Fluorescent Display Scan Timer

This block produces the digit-scan timing for a multiplexed vacuum fluorescent display. Software loads a mode byte, an output-control byte, a slot length and two compare points through a simple write port. A prescaler divides the clock by 32 or by 128, and its ticks drive a slot counter that runs from zero up to the slot length. Each slot drives one digit strobe. The start of each slot is a blanking part, which lasts until the counter reaches the first compare point. The rest of the slot is the active part.

A frame holds 16 or 32 slots. An optional pause of one to three slot periods can follow each frame. The four segment outputs are gated by blanking. They can be inverted, or kept free of blanking. A gradation flag toggles at the two compare points, with a polarity chosen by software. A single-cycle interrupt request fires either at the start of every digit or once at the end of each frame.

Top module: `vfd_scan_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads as zero and `digit_strb`, `seg_out`, `scan_irq` and `grad_out` are all low.
- R2: A write with `wr_en` high stores `wr_data` at one of five addresses: 0 mode, 1 output control, 2 slot length, 3 first compare point, 4 second compare point. Writes to addresses 5 to 7 change nothing.
- R3: Mode bit 3 selects the prescaler: 0 divides the clock by 32, 1 divides it by 128. One slot lasts (slot length + 1) prescaler ticks.
- R4: Exactly one strobe bit, the one numbered by the current slot, is high during the active part of a slot. Mode bit 1 selects a frame of 32 slots (1) or 16 slots (0). After the last slot the frame wraps to slot 0.
- R5: When mode bit 2 (gradation) is set, the frame holds 16 slots whatever mode bit 1 says.
- R6: Display starts, at slot 0 with counter 0, only on a 0-to-1 change of mode bit 0. Writing 1 again while running does not restart it. Writing 0 stops the display, and all strobes are low two cycles after the write.
- R7: Mode bits 5:4 give a pause of that many slot periods after each frame. During the pause all strobes and gated segments are inactive.
- R8: With the pause field at 0, `scan_irq` pulses for one cycle at the start of every slot, the first slot after start included.
- R9: With a nonzero pause field, `scan_irq` pulses once when the last slot of a frame ends, and never at slot starts.
- R10: While the slot counter is below the first compare point, output-control bit 1 blanks the strobes and output-control bit 0 blanks the segment outputs.
- R11: When gradation is on, output-control bit 2 sets the polarity. At 0, the gradation flag is set when the counter reaches the first compare point and cleared at the second. At 1, it is set at the second and cleared at the first. The flag reaches `grad_out` only during the frame part of the scan.
- R12: Output-control bit 3 inverts all four `seg_out` bits. Output-control bit 4 stops blanking from acting on the segment group, so it outputs for the whole slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| seg_in | input | 4 | Segment data for the current digit |
| digit_strb | output | 32 | One-hot digit strobes |
| seg_out | output | 4 | Gated, optionally inverted segment outputs |
| grad_out | output | 1 | Gradation flag |
| scan_irq | output | 1 | Single-cycle scan interrupt request |

## Verification
On every cycle the assertions check that the strobes are one-hot or idle, that the interrupt is a single-cycle pulse raised only while running, that a stop write clears the strobes and gradation within two cycles, and that reset silences all outputs. Slot ordering, frame length, prescaler ratio, pause length, where the interrupt lands, blanking, inversion and gradation polarity depend on configured values over many cycles. The bench's timed scenarios are the only place these are shown.

// File: rtl/vfd_pkg.sv
// Package: shared register addresses, field positions and the decoded
// configuration record used by the fluorescent display scan timer.
package vfd_pkg;
    localparam int REG_W = 8;

    localparam logic [2:0] A_MODE  = 3'd0;
    localparam logic [2:0] A_OUTC  = 3'd1;
    localparam logic [2:0] A_TDISP = 3'd2;
    localparam logic [2:0] A_TOFF1 = 3'd3;
    localparam logic [2:0] A_TOFF2 = 3'd4;

    localparam int MB_RUN     = 0;
    localparam int MB_SLOTS32 = 1;
    localparam int MB_GRAD    = 2;
    localparam int MB_SLOW    = 3;
    localparam int MB_PAUSE   = 4;

    localparam int OB_CMOS = 0;
    localparam int OB_HV   = 1;
    localparam int OB_POL  = 2;
    localparam int OB_REV  = 3;
    localparam int OB_IGN  = 4;

    typedef struct packed {
        logic             run;
        logic             slots32;
        logic             grad_en;
        logic             slow;
        logic [1:0]       pause;
        logic             cmos_toff;
        logic             hv_toff;
        logic             pol;
        logic             rev;
        logic             ign;
        logic [REG_W-1:0] tdisp;
        logic [REG_W-1:0] toff1;
        logic [REG_W-1:0] toff2;
    } vfd_cfg_t;
endpackage

// File: rtl/vfd_regs.sv
// Module: register file. Holds mode, output control, slot length and the
// two compare points. Assumes single-cycle writes and no read path;
// writes to unassigned addresses are dropped.
module vfd_regs
    import vfd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output vfd_cfg_t         cfg
);
    // Capture register writes; all fields clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_MODE: begin
                    cfg.run     <= wr_data[MB_RUN];
                    cfg.slots32 <= wr_data[MB_SLOTS32];
                    cfg.grad_en <= wr_data[MB_GRAD];
                    cfg.slow    <= wr_data[MB_SLOW];
                    cfg.pause   <= wr_data[MB_PAUSE+1:MB_PAUSE];
                end
                A_OUTC: begin
                    cfg.cmos_toff <= wr_data[OB_CMOS];
                    cfg.hv_toff   <= wr_data[OB_HV];
                    cfg.pol       <= wr_data[OB_POL];
                    cfg.rev       <= wr_data[OB_REV];
                    cfg.ign       <= wr_data[OB_IGN];
                end
                A_TDISP: cfg.tdisp <= wr_data;
                A_TOFF1: cfg.toff1 <= wr_data;
                A_TOFF2: cfg.toff2 <= wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vfd_prescaler.sv
// Module: clock prescaler. Emits a one-cycle tick every DIV_FAST or
// DIV_SLOW clocks while enabled; held at zero when disabled so a fresh
// start always begins a full prescaler period.
module vfd_prescaler #(
    parameter int DIV_FAST = 32,
    parameter int DIV_SLOW = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic slow,
    output logic tick
);
    localparam int PRE_W = $clog2(DIV_SLOW);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    // Select the terminal count for the chosen division ratio.
    always_comb begin
        limit = slow ? PRE_W'(DIV_SLOW - 1) : PRE_W'(DIV_FAST - 1);
        tick  = en && (pre_q == limit);
    end

    // Advance the divider, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) pre_q <= '0;
        else                       pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/vfd_slot_seq.sv
// Module: slot sequencer. Counts ticks within a slot, steps the slot index
// across a frame of 16 or 32 slots, inserts the inter-frame pause, raises
// the scan interrupt pulse and keeps the gradation flag. Assumes the
// prescaler is enabled by the `active` output.
module vfd_slot_seq
    import vfd_pkg::*;
#(
    parameter int MAX_SLOTS = 32,
    localparam int SLOT_W = $clog2(MAX_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  vfd_cfg_t          cfg,
    input  logic              tick,
    output logic              active,
    output logic              in_pause,
    output logic [SLOT_W-1:0] slot,
    output logic [REG_W-1:0]  cnt,
    output logic              grad_flag,
    output logic              irq
);
    logic              run_prev;
    logic              start;
    logic [1:0]        pcnt;
    logic [SLOT_W-1:0] last;
    logic [REG_W-1:0]  set_pt;
    logic [REG_W-1:0]  clr_pt;

    // Derive the start edge, the last slot index and the gradation points.
    always_comb begin
        start  = cfg.run && !run_prev;
        last   = (cfg.slots32 && !cfg.grad_en) ? SLOT_W'(MAX_SLOTS - 1)
                                               : SLOT_W'(MAX_SLOTS/2 - 1);
        set_pt = cfg.pol ? cfg.toff2 : cfg.toff1;
        clr_pt = cfg.pol ? cfg.toff1 : cfg.toff2;
    end

    // Sequence slot counter, slot index, pause and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_prev <= 1'b0;
            active   <= 1'b0;
            in_pause <= 1'b0;
            slot     <= '0;
            cnt      <= '0;
            pcnt     <= '0;
            irq      <= 1'b0;
        end else begin
            run_prev <= cfg.run;
            irq      <= 1'b0;
            if (!cfg.run) begin
                active   <= 1'b0;
                in_pause <= 1'b0;
                slot     <= '0;
                cnt      <= '0;
                pcnt     <= '0;
            end else if (start) begin
                active   <= 1'b1;
                in_pause <= 1'b0;
                slot     <= '0;
                cnt      <= '0;
                pcnt     <= '0;
                irq      <= (cfg.pause == 2'd0);
            end else if (active && tick) begin
                if (cnt == cfg.tdisp) begin
                    cnt <= '0;
                    if (in_pause) begin
                        if (pcnt == cfg.pause - 2'd1) begin
                            in_pause <= 1'b0;
                            slot     <= '0;
                        end else begin
                            pcnt <= pcnt + 2'd1;
                        end
                    end else if (slot >= last) begin
                        slot <= '0;
                        irq  <= 1'b1;
                        if (cfg.pause != 2'd0) begin
                            in_pause <= 1'b1;
                            pcnt     <= '0;
                        end
                    end else begin
                        slot <= slot + 1'b1;
                        irq  <= (cfg.pause == 2'd0);
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // Track the gradation flag at its set and clear compare points.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || !cfg.grad_en) grad_flag <= 1'b0;
        else if (cnt == set_pt)                grad_flag <= 1'b1;
        else if (cnt == clr_pt)                grad_flag <= 1'b0;
    end
endmodule

// File: rtl/vfd_scan_timer.sv
// Module: top of the fluorescent display scan timer. Joins the register
// file, prescaler and slot sequencer, then gates strobes and segments with
// the blanking window, applies inversion and forms the gradation output.
// Assumes seg_in already holds the data for the current digit.
module vfd_scan_timer
    import vfd_pkg::*;
#(
    parameter int MAX_SLOTS = 32,
    parameter int SEG_W     = 4,
    parameter int DIV_FAST  = 32,
    parameter int DIV_SLOW  = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [REG_W-1:0]     wr_data,
    input  logic [SEG_W-1:0]     seg_in,
    output logic [MAX_SLOTS-1:0] digit_strb,
    output logic [SEG_W-1:0]     seg_out,
    output logic                 grad_out,
    output logic                 scan_irq
);
    localparam int SLOT_W = $clog2(MAX_SLOTS);

    vfd_cfg_t          cfg;
    logic              tick;
    logic              active;
    logic              in_pause;
    logic [SLOT_W-1:0] slot;
    logic [REG_W-1:0]  cnt;
    logic              grad_flag;
    logic              frame_on;
    logic              below;
    logic              hv_blank;
    logic              cm_blank;
    logic [SEG_W-1:0]  seg_raw;

    vfd_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    vfd_prescaler #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (active),
        .slow  (cfg.slow),
        .tick  (tick)
    );

    vfd_slot_seq #(
        .MAX_SLOTS (MAX_SLOTS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .tick      (tick),
        .active    (active),
        .in_pause  (in_pause),
        .slot      (slot),
        .cnt       (cnt),
        .grad_flag (grad_flag),
        .irq       (scan_irq)
    );

    // Work out the blanking window for each output group.
    always_comb begin
        frame_on = active && !in_pause;
        below    = cnt < cfg.toff1;
        hv_blank = cfg.hv_toff && below;
        cm_blank = cfg.cmos_toff && !cfg.ign && below;
    end

    // Decode the slot index into one strobe bit per slot.
    for (genvar g = 0; g < MAX_SLOTS; g++) begin : g_strb
        assign digit_strb[g] = frame_on && !hv_blank && (slot == SLOT_W'(g));
    end

    // Gate segment data, apply inversion and form gradation output.
    always_comb begin
        seg_raw  = (frame_on && !cm_blank) ? seg_in : '0;
        seg_out  = cfg.rev ? ~seg_raw : seg_raw;
        grad_out = frame_on && cfg.grad_en && grad_flag;
    end
endmodule

// File: rtl/vfd_scan_chk.sv
// Module: property checker for the scan timer, attached by bind. Watches
// the write port and outputs; assumes synchronous active-low reset.
module vfd_scan_chk
    import vfd_pkg::*;
#(
    parameter int MAX_SLOTS = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [2:0]           wr_addr,
    input logic [REG_W-1:0]     wr_data,
    input logic [MAX_SLOTS-1:0] digit_strb,
    input logic                 scan_irq,
    input logic                 grad_out,
    input logic                 run_bit
);
    // R4
    strb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(digit_strb));

    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_irq |=> !scan_irq);

    // R9
    irq_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_irq |-> $past(run_bit));

    // R6
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MODE && !wr_data[MB_RUN])
            |=> ##1 (digit_strb == '0 && !grad_out));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (digit_strb == '0 && !scan_irq && !grad_out));
endmodule

bind vfd_scan_timer vfd_scan_chk #(.MAX_SLOTS(MAX_SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .digit_strb (digit_strb),
    .scan_irq   (scan_irq),
    .grad_out   (grad_out),
    .run_bit    (cfg.run)
);

// File: tb/test_vfd_scan_timer.sv
// Directed bench for the scan timer: one task per scenario, each checking
// its own results against timings derived from the requirements.
module test_vfd_scan_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  seg_in = 4'b1010;
    logic [31:0] digit_strb;
    logic [3:0]  seg_out;
    logic        grad_out;
    logic        scan_irq;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int t0 = 0;
    int irq_cnt = 0;

    vfd_scan_timer i_vfd_scan_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .seg_in     (seg_in),
        .digit_strb (digit_strb),
        .seg_out    (seg_out),
        .grad_out   (grad_out),
        .scan_irq   (scan_irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) if (scan_irq) irq_cnt <= irq_cnt + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic start(input logic [7:0] mode);
        irq_cnt = 0;
        wr(3'd0, mode);
        t0 = cyc + 1;
    endtask

    task automatic stop_all();
        wr(3'd0, 8'h00);
        repeat (3) @(posedge clk);
    endtask

    task automatic at(input int c);
        while (cyc < t0 + c) begin @(posedge clk); #1; end
    endtask

    task automatic t_reset();
        chk(digit_strb == 0 && seg_out == 0 && !scan_irq && !grad_out, "R1",
            {digit_strb, seg_out, grad_out, scan_irq}, 0);
    endtask

    task automatic t_basic();   // R3 R4 R8: /32, tdisp 1 => 64-cycle slots
        stop_all();
        wr(3'd1, 8'h00); wr(3'd2, 8'd1); wr(3'd3, 8'd0);
        start(8'h01);
        at(30);          chk(digit_strb == 32'h1, "R4 slot0", digit_strb, 32'h1);
        at(5*64+30);     chk(digit_strb == 32'h20, "R3 slot5", digit_strb, 32'h20);
        at(15*64+30);    chk(digit_strb == 32'h8000, "R4 slot15", digit_strb, 32'h8000);
        at(1020);        chk(irq_cnt == 16, "R8 irq per slot", irq_cnt, 16);
        at(16*64+30);    chk(digit_strb == 32'h1, "R4 wrap16", digit_strb, 32'h1);
    endtask

    task automatic t_slots32();
        stop_all();
        wr(3'd2, 8'd0);
        start(8'h03);
        at(20*32+10);    chk(digit_strb == 32'h100000, "R4 slot20", digit_strb, 32'h100000);
        at(32*32+10);    chk(digit_strb == 32'h1, "R4 wrap32", digit_strb, 32'h1);
    endtask

    task automatic t_grad16();
        stop_all();
        wr(3'd2, 8'd0);
        start(8'h07);
        at(15*32+10);    chk(digit_strb == 32'h8000, "R5 slot15", digit_strb, 32'h8000);
        at(16*32+10);    chk(digit_strb == 32'h1, "R5 forced16", digit_strb, 32'h1);
    endtask

    task automatic t_slow();
        stop_all();
        wr(3'd2, 8'd0);
        start(8'h09);
        at(3*128+60);    chk(digit_strb == 32'h8, "R3 div128", digit_strb, 32'h8);
    endtask

    task automatic t_pause();   // pause 2 slots of 32 cycles after 512-cycle frame
        stop_all();
        wr(3'd2, 8'd0);
        start(8'h21);
        at(10);
        chk(digit_strb == 32'h1, "R7 frame", digit_strb, 32'h1);
        chk(irq_cnt == 0, "R9 no slot irq", irq_cnt, 0);
        at(512+10);
        chk(digit_strb == 0 && seg_out == 0, "R7 pause idle", {digit_strb, seg_out}, 0);
        chk(irq_cnt == 1, "R9 end irq", irq_cnt, 1);
        at(512+63);      chk(digit_strb == 0, "R7 pause len", digit_strb, 0);
        at(512+64+10);
        chk(digit_strb == 32'h1 && seg_out == 4'b1010, "R7 resume", {digit_strb, seg_out}, {32'h1, 4'b1010});
        chk(irq_cnt == 1, "R9 single", irq_cnt, 1);
    endtask

    task automatic t_blank();   // tdisp 7, toff1 4: blank while c < 128
        stop_all();
        wr(3'd1, 8'h03); wr(3'd2, 8'd7); wr(3'd3, 8'd4);
        start(8'h01);
        at(60);  chk(digit_strb == 0 && seg_out == 0, "R10 blank", {digit_strb, seg_out}, 0);
        at(200); chk(digit_strb == 1 && seg_out == 4'b1010, "R10 active", {digit_strb, seg_out}, {32'h1, 4'b1010});
        stop_all();
        wr(3'd1, 8'h0B);
        start(8'h01);
        at(60);  chk(seg_out == 4'b1111, "R12 reverse blank", seg_out, 4'b1111);
        at(200); chk(seg_out == 4'b0101, "R12 reverse data", seg_out, 4'b0101);
        stop_all();
        wr(3'd1, 8'h13);
        start(8'h01);
        at(60);  chk(seg_out == 4'b1010 && digit_strb == 0, "R12 ignore toff", {digit_strb, seg_out}, 4'b1010);
    endtask

    task automatic t_grad();    // tdisp 7, toff1 2, toff2 5: cnt = c/32
        stop_all();
        wr(3'd1, 8'h00); wr(3'd2, 8'd7); wr(3'd3, 8'd2); wr(3'd4, 8'd5);
        start(8'h05);
        at(42);  chk(!grad_out, "R11 pol0 cnt1", grad_out, 0);
        at(106); chk(grad_out, "R11 pol0 cnt3", grad_out, 1);
        at(202); chk(!grad_out, "R11 pol0 cnt6", grad_out, 0);
        stop_all();
        wr(3'd1, 8'h04);
        start(8'h05);
        at(106);    chk(!grad_out, "R11 pol1 cnt3", grad_out, 0);
        at(202);    chk(grad_out, "R11 pol1 cnt6", grad_out, 1);
        at(256+42); chk(grad_out, "R11 pol1 next slot", grad_out, 1);
    endtask

    task automatic t_restart(); // tdisp 1 => 64-cycle slots
        stop_all();
        wr(3'd1, 8'h00); wr(3'd2, 8'd1); wr(3'd3, 8'd0);
        start(8'h01);
        at(100); chk(digit_strb == 32'h2, "R6 slot1", digit_strb, 32'h2);
        wr(3'd0, 8'h01);
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'h00);
        at(150); chk(digit_strb == 32'h4, "R6 R2 no restart", digit_strb, 32'h4);
        wr(3'd0, 8'h00);
        @(posedge clk); #1;
        chk(digit_strb == 0, "R6 stop", digit_strb, 0);
        start(8'h01);
        at(30);  chk(digit_strb == 32'h1, "R6 restart", digit_strb, 32'h1);
    endtask

    initial begin
        #100000000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_slots32();
        t_grad16();
        t_slow();
        t_pause();
        t_blank();
        t_grad();
        t_restart();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule